// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends characters on one serial line using start/stop framing. A character is written in parallel by pulling a low-active load strobe from high to low. The strobe may come from another clock domain, so it is synchronized before its edge is detected. The character goes into a holding buffer and then into a separate shift stage. The line then carries one space start bit, seven code bits with the least significant first, an even-parity bit and one mark stop bit. That is ten bit-times in all.

Because the holding buffer is separate from the shift stage, a second character can be written while the first is still on the line. A buffer-empty status tells the writer when the holding buffer can take another character. A divider built into the block makes an enable pulse at sixteen times the bit rate from the system clock. Every bit lasts sixteen of those pulses.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset, and whenever no character is being sent, `txd` is at mark (1) and `hold_empty` is 1.
- R2: Every frame begins with a start bit at space (0) that lasts one bit-time.
- R3: After the start bit, `din[0]` through `din[6]` are sent in that order, least significant first, each for one bit-time.
- R4: The ninth line bit (after the start bit) is `din[0]^din[1]^...^din[6]`, so the eight transmitted data bits hold an even number of ones. `din[7]` has no effect on the line.
- R5: The tenth bit is a stop bit at mark (1), so a frame lasts ten bit-times. A bit-time is 16 pulses of the internal rate enable, and that enable pulses once every `DIV` clocks. Two frames sent back to back therefore start between `159*DIV+2` and `160*DIV+1` clocks apart.
- R6: A character is captured only on a high-to-low transition of `load_n`, after a two-flop synchronizer. Holding `load_n` low, or its low-to-high transition, starts no further frame.
- R7: `hold_empty` falls in the cycle after the synchronized strobe edge is seen, which is the third clock edge after `load_n` falls. It stays low while the character waits for the shift stage.
- R8: If the shift stage is idle, the held character moves into it on the next clock edge. At that edge `hold_empty` returns to 1 and `txd` drops to the start bit.
- R9: A character loaded while another is being sent is held until the current frame ends. It then moves into the shift stage: `hold_empty` rises in the same cycle that its start bit begins, one clock after the previous stop bit completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_n | input | 1 | Active-low load strobe; its falling edge captures `din` |
| din | input | 8 | Character to send; bits 6..0 are the code, bit 7 is unused |
| txd | output | 1 | Serial line, idles at 1 |
| hold_empty | output | 1 | 1 when the holding buffer can accept a character |

## Verification
All 128 seven-bit codes are sent one at a time. Bit 7 of the input is toggled in a pattern that does not match parity. This tells apart bit order, parity polarity, and any leakage of bit 7 into the frame. Single loads into an idle block check the exact cycle when buffer-empty falls and rises. A strobe held low for a whole frame and then released checks that only the falling edge loads a character. A second character written in the middle of a frame checks the double buffering: buffer-empty stays low until the first stop bit ends, the second frame follows with the right content, and the spacing between the two start bits matches the bit-time arithmetic.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int CODE_W  = 7;
  localparam int DATA_W  = CODE_W + 1;
  localparam int FRAME_W = CODE_W + 3;
  localparam int BIT_CNT_W = $clog2(FRAME_W);

  function automatic logic even_parity(input logic [CODE_W-1:0] code);
    return ^code;
  endfunction

  // Frame as it leaves the line, element 0 first: start, code LSB first, parity, stop.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [CODE_W-1:0] code);
    return {1'b1, even_parity(code), code, 1'b0};
  endfunction
endpackage

// File: rtl/sertx_tick_gen.sv
module sertx_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (cnt == CW'(DIV - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(DIV - 1));

      assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/sertx_load_sync.sv
module sertx_load_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  output logic load_evt
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= load_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign load_evt = prev_q & ~sync_q;

  assert_single_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !load_evt);
endmodule

// File: rtl/sertx_hold_buf.sv
module sertx_hold_buf
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [CODE_W-1:0] din,
  input  logic              shift_busy,
  output logic              xfer,
  output logic [CODE_W-1:0] xfer_code,
  output logic              hold_empty
);
  logic              full_q;
  logic [CODE_W-1:0] code_q;

  assign xfer      = full_q & ~shift_busy;
  assign xfer_code = code_q;
  assign hold_empty = ~full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      code_q <= '0;
    end else if (load_evt) begin
      full_q <= 1'b1;
      code_q <= din;
    end else if (xfer) begin
      full_q <= 1'b0;
    end
  end

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !hold_empty);
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !load_evt) |=> hold_empty);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              xfer,
  input  logic [CODE_W-1:0] xfer_code,
  output logic              busy,
  output logic              bit_end,
  output logic              txd
);
  localparam int SUB_W = $clog2(OVS);

  logic [FRAME_W-1:0]   shreg;
  logic [SUB_W-1:0]     sub_cnt;
  logic [BIT_CNT_W-1:0] bit_cnt;
  logic                 last_bit;

  assign bit_end  = busy & tick & (sub_cnt == SUB_W'(OVS - 1));
  assign last_bit = (bit_cnt == BIT_CNT_W'(FRAME_W - 1));
  assign txd      = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '1;
      sub_cnt <= '0;
      bit_cnt <= '0;
      busy    <= 1'b0;
    end else if (xfer) begin
      shreg   <= build_frame(xfer_code);
      sub_cnt <= '0;
      bit_cnt <= '0;
      busy    <= 1'b1;
    end else if (bit_end) begin
      sub_cnt <= '0;
      shreg   <= {1'b1, shreg[FRAME_W-1:1]};
      bit_cnt <= bit_cnt + 1'b1;
      if (last_bit) busy <= 1'b0;
    end else if (busy && tick) begin
      sub_cnt <= sub_cnt + 1'b1;
    end
  end

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(bit_end) && !$past(xfer)) |-> $stable(txd));
  assert_stop_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_bit) |-> txd);
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
  import sertx_pkg::*;
#(
  parameter int DIV = 4,
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic [DATA_W-1:0] din,
  output logic              txd,
  output logic              hold_empty
);
  logic              tick, load_evt, xfer, shift_busy, bit_end;
  logic [CODE_W-1:0] xfer_code;
  logic              unused_din_msb;

  assign unused_din_msb = din[DATA_W-1];

  sertx_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  sertx_load_sync u_sync (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_evt(load_evt));

  sertx_hold_buf u_hold (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .din(din[CODE_W-1:0]),
    .shift_busy(shift_busy), .xfer(xfer), .xfer_code(xfer_code),
    .hold_empty(hold_empty));

  sertx_shifter #(.OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .xfer(xfer),
    .xfer_code(xfer_code), .busy(shift_busy), .bit_end(bit_end), .txd(txd));

  assert_start_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !txd);
  assert_xfer_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> shift_busy);
endmodule

// File: tb/serial_tx_dbuf_tb.sv
module serial_tx_dbuf_tb;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic       txd, hold_empty;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  serial_tx_dbuf #(.DIV(D), .OVS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .txd(txd), .hold_empty(hold_empty));

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [9:0] expect_frame(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 7; i++) if (b[i]) ones++;
    return {1'b1, logic'(ones % 2 == 1), b[6:0], 1'b0};
  endfunction

  // Assumes the current negedge is the first one with the start bit visible.
  task automatic sample_frame(output logic [9:0] f);
    repeat (8 * D) @(posedge clk);
    @(negedge clk);
    f[0] = txd;
    for (int n = 1; n < 10; n++) begin
      repeat (16 * D) @(posedge clk);
      @(negedge clk);
      f[n] = txd;
    end
  endtask

  task automatic wait_start(output int waited);
    waited = 0;
    while (txd !== 1'b0 && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 4000) chk(0, "R5 start timeout", waited, 0);
  endtask

  task automatic check_frame(input logic [9:0] f, input logic [7:0] b);
    logic [9:0] e;
    e = expect_frame(b);
    chk(f[0] == 1'b0, "R2 start bit", f[0], 0);
    chk(f[7:1] == e[7:1], "R3 code bits", f[7:1], e[7:1]);
    chk(f[8] == e[8], "R4 parity bit", f[8], e[8]);
    chk(f[9] == 1'b1, "R5 stop bit", f[9], 1);
  endtask

  task automatic idle_check(input int cycles, input string tag);
    bit ok = 1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || hold_empty !== 1'b1) ok = 0;
    end
    chk(ok, tag, {txd, hold_empty}, 3);
  endtask

  task automatic send_single(input logic [7:0] b, input bit hold_low);
    logic [9:0] f;
    @(negedge clk);
    din = b;
    load_n = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(hold_empty == 1'b1, "R7 no capture before sync", hold_empty, 1);
    @(posedge clk); @(negedge clk);
    chk(hold_empty == 1'b0, "R7 empty falls", hold_empty, 0);
    @(posedge clk); @(negedge clk);
    chk(hold_empty == 1'b1, "R8 empty rises", hold_empty, 1);
    chk(txd == 1'b0, "R8 start at transfer", txd, 0);
    if (!hold_low) load_n = 1'b1;
    sample_frame(f);
    check_frame(f, b);
    if (hold_low) begin
      idle_check(40 * D, "R6 held low no reload");
      load_n = 1'b1;
      idle_check(40 * D, "R6 rising edge no load");
    end else begin
      idle_check(10 * D, "R1 idle after frame");
    end
  endtask

  task automatic pulse_load(input logic [7:0] b);
    @(negedge clk);
    din = b;
    load_n = 1'b0;
    repeat (3) @(negedge clk);
    load_n = 1'b1;
  endtask

  task automatic back_to_back(input logic [7:0] a, input logic [7:0] b);
    logic [9:0] fa, fb;
    int w, span;
    pulse_load(a);
    wait_start(w);
    span = 0;
    fork
      sample_frame(fa);
      begin
        repeat (40) @(negedge clk);
        pulse_load(b);
        repeat (6) @(negedge clk);
        chk(hold_empty == 1'b0, "R7 held behind busy stage", hold_empty, 0);
      end
    join
    chk(hold_empty == 1'b0, "R9 empty low during stop", hold_empty, 0);
    check_frame(fa, a);
    while (txd !== 1'b0 && span < 4000) begin
      @(negedge clk);
      span++;
    end
    chk(hold_empty == 1'b1, "R9 empty rises with next start", hold_empty, 1);
    span = span + 8 * D + 9 * 16 * D;
    chk(span >= 159 * D + 2 && span <= 160 * D + 1, "R5 start spacing", span, 160 * D);
    sample_frame(fb);
    check_frame(fb, b);
    idle_check(10 * D, "R1 idle after pair");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(txd == 1'b1, "R1 txd in reset", txd, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd after reset", txd, 1);
    chk(hold_empty == 1'b1, "R1 empty after reset", hold_empty, 1);
    idle_check(20, "R1 idle without load");

    for (int c = 0; c < 128; c++) begin
      logic [7:0] b;
      b = {c[0] ^ c[2], c[6:0]};
      send_single(b, 1'b0);
    end

    send_single(8'h3C, 1'b1);
    send_single(8'hC1, 1'b1);
    back_to_back(8'h55, 8'h2A);
    back_to_back(8'h7F, 8'h80);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule